// File: doc/BRIEF.md
# MII Management Master

This block is a register-driven management master. It runs single read or write transactions to an external Ethernet PHY over the two-wire MDC/MDIO management link. Software sets the MDC divisor and the preamble option in a control register. For a write it first loads a data register. It then writes a command word that carries the operation, a 5-bit PHY address and a 5-bit register number, and polls a busy flag. A read leaves its 16-bit result in the same data register once busy drops.

MDC is derived from the system clock by a programmable divisor, which is latched at the start of every frame. MDIO leaves the block as a separate output value and output enable, so that the pad drives the wire only when the master owns it. Software can omit the 32-bit preamble when the attached PHY accepts frames without one. A self-clearing soft reset aborts any frame and restores the register defaults.

Top module: `mdio_mgmt_top`

## Requirements
- R1: The command register (word address 1) takes a read request in bit 15, a write request in bit 14, the PHY address in bits 9:5 and the register number in bits 4:0. A write with exactly one of bits 15 and 14 set starts a frame. A write with neither or both set starts nothing. The register reads back the last accepted command.
- R2: Bit 0 of the status register (word address 3) reads 1 from the clock edge that accepts a command until the frame's final MDC falling edge, and reads 0 otherwise.
- R3: A command write that arrives while busy is 1 is ignored, including one on the very edge on which the frame completes. The running frame finishes unchanged and no further frame follows.
- R4: A write frame is 32 ones, 01, 01, PHY address, register number, 10, then the 16 bits of the data register (word address 2) as held when the command was accepted, each field MSB first. mdio_oe stays 1 for all 64 bits. MDIO changes only on the clock edge where MDC falls.
- R5: A read frame uses opcode 10. mdio_oe is 1 up to the register number and 0 from the turnaround onward. The 16 data bits are sampled on MDC rising edges, MSB first, into data register bits 15:0, and bits 31:16 read 0.
- R6: When control bit 8 is 1, frames omit the preamble and last 32 MDC periods.
- R7: With control field bits 16:9 holding F, the divisor is D = F+1, and a value of 0 is treated as D = 2. In each bit period MDC is low for D - floor(D/2) clocks and high for floor(D/2) clocks, and MDC only toggles while busy. After reset F is 39.
- R8: When no frame is running, MDC is 0 and mdio_oe is 0.
- R9: Writing control bit 0 as 1 aborts any frame. Control bit 0 then reads 1 for SRST_CYCLES clocks, during which all register writes and commands are ignored. Afterwards the control fields hold their reset values and the data register holds 0.
- R10: Writes to the data register while busy is 1 are ignored.
- R11: reg_rdata shows the register selected by reg_addr at the previous clock edge (control 0, command 1, data 2, status 3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| mdc | output | 1 | Management clock to the PHY |
| mdio_i | input | 1 | MDIO value seen at the pad |
| mdio_o | output | 1 | MDIO value to drive |
| mdio_oe | output | 1 | MDIO drive enable |

## Verification
A new command write and the completion of the running frame can land on the same clock edge: the edge where the last MDC falling edge drops busy. The bench counts MDC rising edges until the last bit, waits out the MDC high time, and issues a second command on exactly that edge. The command must be ignored: no further MDC edge appears, status stays 0 and the command readback keeps the first command. A normal command issued afterwards must then be accepted.

// File: rtl/mdio_mgmt_pkg.sv
`timescale 1ns/1ps
package mdio_mgmt_pkg;
  localparam int MDIO_DATA_W = 16;
  localparam int BUS_W       = 32;

  typedef enum logic [1:0] {
    A_CTRL = 2'd0,
    A_CMD  = 2'd1,
    A_DATA = 2'd2,
    A_STAT = 2'd3
  } reg_addr_e;

  localparam int CMD_RD_BIT    = 15;
  localparam int CMD_WR_BIT    = 14;
  localparam int CMD_PHY_LSB   = 5;
  localparam int CMD_REG_LSB   = 0;
  localparam int CTRL_SRST_BIT = 0;
  localparam int CTRL_NOPRE    = 8;
  localparam int CTRL_DIV_LSB  = 9;
endpackage

// File: rtl/mdio_clk_div.sv
`timescale 1ns/1ps
module mdio_clk_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             abort,
  input  logic             start,
  input  logic             run,
  input  logic [DIV_W-1:0] div_field,
  output logic             mdc,
  output logic             rise_evt,
  output logic             fall_evt
);
  logic [DIV_W-1:0] per_m1_q, lo_m1_q, cnt_q;
  logic [DIV_W-1:0] pm1_new;
  logic [DIV_W:0]   d_new, lo_new, lo_m1_new;
  logic             mdc_q;

  always_comb begin
    pm1_new   = (div_field == '0) ? DIV_W'(1) : div_field;
    d_new     = {1'b0, pm1_new} + 1'b1;
    lo_new    = d_new - (d_new >> 1);
    lo_m1_new = lo_new - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      per_m1_q <= DIV_W'(1);
      lo_m1_q  <= '0;
    end else if (start) begin
      per_m1_q <= pm1_new;
      lo_m1_q  <= lo_m1_new[DIV_W-1:0];
    end
  end

  assign rise_evt = run && (cnt_q == lo_m1_q);
  assign fall_evt = run && (cnt_q == per_m1_q);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt_q <= '0;
    else if (cnt_q == per_m1_q) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || abort || !run) mdc_q <= 1'b0;
    else if (fall_evt) mdc_q <= 1'b0;
    else if (rise_evt) mdc_q <= 1'b1;
  end

  assign mdc = mdc_q;
endmodule

// File: rtl/mdio_frame_engine.sv
`timescale 1ns/1ps
module mdio_frame_engine #(
  parameter int PRE_LEN = 32,
  parameter int DATA_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              abort,
  input  logic              start,
  input  logic              start_rd,
  input  logic              start_nopre,
  input  logic [4:0]        start_phy,
  input  logic [4:0]        start_reg,
  input  logic [DATA_W-1:0] start_wdata,
  input  logic              rise_evt,
  input  logic              fall_evt,
  input  logic              mdio_i,
  output logic              busy,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              rd_done,
  output logic [DATA_W-1:0] rd_data
);
  localparam int BODY_LEN  = 2 + 2 + 5 + 5 + 2 + DATA_W;
  localparam int FRAME_LEN = PRE_LEN + BODY_LEN;
  localparam int IDX_W     = $clog2(FRAME_LEN);

  logic [BODY_LEN-1:0]  body;
  logic [FRAME_LEN-1:0] image, sh_q;
  logic [IDX_W-1:0]     idx_q, last_q, idx_nxt;
  logic                 active_q, op_rd_q, mdo_q, oe_q, done_q;
  logic [DATA_W-1:0]    shin_q;

  always_comb begin
    body = {2'b01,
            start_rd ? 2'b10 : 2'b01,
            start_phy, start_reg,
            start_rd ? 2'b00 : 2'b10,
            start_rd ? {DATA_W{1'b0}} : start_wdata};
    if (start_nopre) image = {body, {PRE_LEN{1'b0}}};
    else             image = {{PRE_LEN{1'b1}}, body};
  end

  assign idx_nxt = idx_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      active_q <= 1'b0;
      op_rd_q  <= 1'b0;
      mdo_q    <= 1'b0;
      oe_q     <= 1'b0;
      done_q   <= 1'b0;
      idx_q    <= '0;
      last_q   <= '0;
      sh_q     <= '0;
      shin_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (start && !active_q) begin
        active_q <= 1'b1;
        op_rd_q  <= start_rd;
        sh_q     <= image;
        idx_q    <= '0;
        last_q   <= start_nopre ? IDX_W'(BODY_LEN - 1) : IDX_W'(FRAME_LEN - 1);
        mdo_q    <= image[FRAME_LEN-1];
        oe_q     <= 1'b1;
        shin_q   <= '0;
      end else if (active_q) begin
        if (rise_evt && op_rd_q && (idx_q >= (last_q - IDX_W'(DATA_W - 1))))
          shin_q <= {shin_q[DATA_W-2:0], mdio_i};
        if (fall_evt) begin
          if (idx_q == last_q) begin
            active_q <= 1'b0;
            oe_q     <= 1'b0;
            mdo_q    <= 1'b0;
            done_q   <= op_rd_q;
          end else begin
            idx_q <= idx_nxt;
            sh_q  <= sh_q << 1;
            mdo_q <= sh_q[FRAME_LEN-2];
            oe_q  <= !op_rd_q || (idx_nxt <= (last_q - IDX_W'(DATA_W + 2)));
          end
        end
      end
    end
  end

  assign busy    = active_q;
  assign mdio_o  = mdo_q;
  assign mdio_oe = oe_q;
  assign rd_done = done_q;
  assign rd_data = shin_q;
endmodule

// File: rtl/mdio_reg_file.sv
`timescale 1ns/1ps
module mdio_reg_file
  import mdio_mgmt_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int DIV_RESET   = 39,
  parameter int SRST_CYCLES = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   reg_wr,
  input  logic [1:0]             reg_addr,
  input  logic [BUS_W-1:0]       reg_wdata,
  output logic [BUS_W-1:0]       reg_rdata,
  input  logic                   eng_busy,
  input  logic                   rd_done,
  input  logic [MDIO_DATA_W-1:0] rd_data,
  output logic                   start,
  output logic                   start_rd,
  output logic [4:0]             start_phy,
  output logic [4:0]             start_reg,
  output logic [MDIO_DATA_W-1:0] data_val,
  output logic                   nopre,
  output logic [DIV_W-1:0]       div_field,
  output logic                   soft_rst
);
  localparam int CNT_W = $clog2(SRST_CYCLES + 1);

  logic [CNT_W-1:0]       srst_cnt_q;
  logic                   srst_act;
  logic                   nopre_q;
  logic [DIV_W-1:0]       div_q;
  logic [15:0]            cmd_q;
  logic [MDIO_DATA_W-1:0] data_q;
  logic [BUS_W-1:0]       rdata_q, ctrl_rd;
  logic                   wr_ctrl, wr_cmd, wr_data, cmd_ok;
  logic                   unused_wdata;

  assign unused_wdata = ^reg_wdata;
  assign srst_act = (srst_cnt_q != '0);
  assign wr_ctrl  = reg_wr && (reg_addr == A_CTRL) && !srst_act;
  assign wr_cmd   = reg_wr && (reg_addr == A_CMD)  && !srst_act;
  assign wr_data  = reg_wr && (reg_addr == A_DATA) && !srst_act;
  assign cmd_ok   = reg_wdata[CMD_RD_BIT] ^ reg_wdata[CMD_WR_BIT];
  assign start    = wr_cmd && cmd_ok && !eng_busy;

  always_ff @(posedge clk) begin
    if (rst) srst_cnt_q <= '0;
    else if (wr_ctrl && reg_wdata[CTRL_SRST_BIT]) srst_cnt_q <= CNT_W'(SRST_CYCLES);
    else if (srst_act) srst_cnt_q <= srst_cnt_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || srst_act) begin
      nopre_q <= 1'b0;
      div_q   <= DIV_W'(DIV_RESET);
    end else if (wr_ctrl && !reg_wdata[CTRL_SRST_BIT]) begin
      nopre_q <= reg_wdata[CTRL_NOPRE];
      div_q   <= reg_wdata[CTRL_DIV_LSB +: DIV_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || srst_act) cmd_q <= '0;
    else if (start)
      cmd_q <= {reg_wdata[CMD_RD_BIT], reg_wdata[CMD_WR_BIT], 4'b0000,
                reg_wdata[CMD_PHY_LSB +: 5], reg_wdata[CMD_REG_LSB +: 5]};
  end

  always_ff @(posedge clk) begin
    if (rst || srst_act) data_q <= '0;
    else if (rd_done) data_q <= rd_data;
    else if (wr_data && !eng_busy) data_q <= reg_wdata[MDIO_DATA_W-1:0];
  end

  always_comb begin
    ctrl_rd = '0;
    ctrl_rd[CTRL_DIV_LSB +: DIV_W] = div_q;
    ctrl_rd[CTRL_NOPRE]            = nopre_q;
    ctrl_rd[CTRL_SRST_BIT]         = srst_act;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else begin
      case (reg_addr)
        A_CTRL:  rdata_q <= ctrl_rd;
        A_CMD:   rdata_q <= {{(BUS_W-16){1'b0}}, cmd_q};
        A_DATA:  rdata_q <= {{(BUS_W-MDIO_DATA_W){1'b0}}, data_q};
        default: rdata_q <= {{(BUS_W-1){1'b0}}, eng_busy};
      endcase
    end
  end

  assign reg_rdata = rdata_q;
  assign start_rd  = reg_wdata[CMD_RD_BIT];
  assign start_phy = reg_wdata[CMD_PHY_LSB +: 5];
  assign start_reg = reg_wdata[CMD_REG_LSB +: 5];
  assign data_val  = data_q;
  assign nopre     = nopre_q;
  assign div_field = div_q;
  assign soft_rst  = srst_act;
endmodule

// File: rtl/mdio_mgmt_top.sv
`timescale 1ns/1ps
module mdio_mgmt_top
  import mdio_mgmt_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int DIV_RESET   = 39,
  parameter int SRST_CYCLES = 8,
  parameter int PRE_LEN     = 32
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  input  logic        mdio_i,
  output logic        mdio_o,
  output logic        mdio_oe
);
  logic                   eng_busy, rd_done, start, start_rd, nopre, soft_rst;
  logic                   rise_evt, fall_evt;
  logic [4:0]             start_phy, start_reg;
  logic [MDIO_DATA_W-1:0] rd_data, data_val;
  logic [DIV_W-1:0]       div_field;

  mdio_reg_file #(
    .DIV_W(DIV_W), .DIV_RESET(DIV_RESET), .SRST_CYCLES(SRST_CYCLES)
  ) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eng_busy(eng_busy),
    .rd_done(rd_done), .rd_data(rd_data), .start(start), .start_rd(start_rd),
    .start_phy(start_phy), .start_reg(start_reg), .data_val(data_val),
    .nopre(nopre), .div_field(div_field), .soft_rst(soft_rst)
  );

  mdio_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .abort(soft_rst), .start(start), .run(eng_busy),
    .div_field(div_field), .mdc(mdc), .rise_evt(rise_evt), .fall_evt(fall_evt)
  );

  mdio_frame_engine #(.PRE_LEN(PRE_LEN), .DATA_W(MDIO_DATA_W)) u_eng (
    .clk(clk), .rst(rst), .abort(soft_rst), .start(start), .start_rd(start_rd),
    .start_nopre(nopre), .start_phy(start_phy), .start_reg(start_reg),
    .start_wdata(data_val), .rise_evt(rise_evt), .fall_evt(fall_evt),
    .mdio_i(mdio_i), .busy(eng_busy), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .rd_done(rd_done), .rd_data(rd_data)
  );
endmodule

// File: rtl/mdio_mgmt_chk.sv
`timescale 1ns/1ps
module mdio_mgmt_chk
  import mdio_mgmt_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       busy,
  input logic       soft_rst,
  input logic       mdc,
  input logic       mdio_o,
  input logic       mdio_oe,
  input logic       reg_wr,
  input logic [1:0] reg_addr
);
  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mdc && !mdio_oe));

  assert_busy_from_cmd_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(reg_wr && (reg_addr == A_CMD)));

  assert_data_stable_high_R4: assert property (@(posedge clk) disable iff (rst)
    (mdc && $past(mdc)) |-> $stable(mdio_o));

  assert_mdc_only_busy_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(mdc) |-> busy);

  assert_soft_reset_idle_R9: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> !busy);
endmodule

bind mdio_mgmt_top mdio_mgmt_chk i_chk (
  .clk(clk), .rst(rst), .busy(eng_busy), .soft_rst(soft_rst), .mdc(mdc),
  .mdio_o(mdio_o), .mdio_oe(mdio_oe), .reg_wr(reg_wr), .reg_addr(reg_addr)
);

// File: tb/test_mdio_mgmt_top.sv
`timescale 1ns/1ps
module test_mdio_mgmt_top;
  localparam logic [1:0] CTRL = 2'd0, CMD = 2'd1, DATA = 2'd2, STAT = 2'd3;

  logic        clk = 1'b0, rst = 1'b1, reg_wr = 1'b0, mdio_i = 1'b1;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe;

  int checks = 0, errors = 0;
  logic cap_bits [0:127];
  logic cap_oe   [0:127];
  int   cap_n = 0;
  int   frame_len = 64;
  logic [15:0] phy_resp = '0;
  int   stab_err = 0;
  logic prev_mdc = 1'b0, prev_o = 1'b0;

  mdio_mgmt_top i_mdio_mgmt_top (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  always #2.5 clk = ~clk;

  always @(posedge mdc) begin
    if (cap_n < 128) begin
      cap_bits[cap_n] = mdio_o;
      cap_oe[cap_n]   = mdio_oe;
    end
    cap_n++;
  end

  always @(negedge mdc) begin
    if (cap_n >= frame_len - 16 && cap_n < frame_len)
      mdio_i = phy_resp[15 - (cap_n - (frame_len - 16))];
    else
      mdio_i = 1'b1;
  end

  always @(negedge clk) begin
    if (mdc === 1'b1 && prev_mdc === 1'b1 && mdio_o !== prev_o) stab_err++;
    prev_mdc = mdc;
    prev_o   = mdio_o;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 4000; i++) begin
      rd_reg(STAT, s);
      if (s[0] == 1'b0) return;
    end
    chk("R2 busy timeout", 32'd1, 32'd0);
  endtask

  function automatic logic [31:0] cmd_word(input bit rd, input logic [4:0] phy, input logic [4:0] rg);
    return (rd ? 32'h8000 : 32'h4000) | (32'(phy) << 5) | 32'(rg);
  endfunction

  function automatic logic [63:0] exp_frame(input bit rd, input logic [4:0] phy,
                                            input logic [4:0] rg, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, rg,
            (rd ? 2'b00 : 2'b10), (rd ? 16'h0000 : d)};
  endfunction

  function automatic int mism(input logic [63:0] f, input int first, input int n, input int len);
    int m = 0;
    for (int i = first; i < n; i++) if (cap_bits[i] !== f[len-1-i]) m++;
    return m;
  endfunction

  task automatic t_reset();
    logic [31:0] v;
    rd_reg(CTRL, v); chk("R7 R11 control default", v, 32'h0000_4E00);
    rd_reg(STAT, v); chk("R2 status after reset", v, 32'd0);
    rd_reg(DATA, v); chk("R11 data after reset", v, 32'd0);
    chk("R8 mdc idle", {31'd0, mdc}, 32'd0);
    chk("R8 oe idle", {31'd0, mdio_oe}, 32'd0);
  endtask

  task automatic t_write_frame();
    logic [31:0] v;
    int oe_ones = 0;
    wr_reg(DATA, 32'h0000_A5C3);
    cap_n = 0; stab_err = 0; frame_len = 64;
    wr_reg(CMD, cmd_word(0, 5'h11, 5'h0A));
    rd_reg(STAT, v); chk("R2 busy during write", v, 32'd1);
    wait_idle();
    chk("R4 write bit count", 32'(cap_n), 32'd64);
    chk("R4 write frame bits", 32'(mism(exp_frame(0, 5'h11, 5'h0A, 16'hA5C3), 0, 64, 64)), 32'd0);
    for (int i = 0; i < 64; i++) if (cap_oe[i] === 1'b1) oe_ones++;
    chk("R4 oe held for write", 32'(oe_ones), 32'd64);
    chk("R4 no change while mdc high", 32'(stab_err), 32'd0);
    rd_reg(DATA, v); chk("R4 data kept after write", v, 32'h0000_A5C3);
    rd_reg(CMD, v); chk("R1 command readback", v, cmd_word(0, 5'h11, 5'h0A));
    chk("R8 mdc after frame", {31'd0, mdc}, 32'd0);
    chk("R8 oe after frame", {31'd0, mdio_oe}, 32'd0);
  endtask

  task automatic t_read_frame();
    logic [31:0] v;
    int bad_oe = 0;
    phy_resp = 16'h3C96; frame_len = 64; cap_n = 0;
    wr_reg(CMD, cmd_word(1, 5'h05, 5'h1F));
    wait_idle();
    chk("R5 read header bits", 32'(mism(exp_frame(1, 5'h05, 5'h1F, 16'h0), 0, 46, 64)), 32'd0);
    for (int i = 0; i < 64; i++) if (cap_oe[i] !== (i <= 45)) bad_oe++;
    chk("R5 read drive pattern", 32'(bad_oe), 32'd0);
    rd_reg(DATA, v); chk("R5 read result", v, 32'h0000_3C96);
  endtask

  task automatic t_nopre();
    logic [31:0] v;
    wr_reg(CTRL, (32'd3 << 9) | (32'd1 << 8));
    wr_reg(DATA, 32'h0000_0F3C);
    cap_n = 0; frame_len = 32;
    wr_reg(CMD, cmd_word(0, 5'h0C, 5'h03));
    wait_idle();
    chk("R6 short write length", 32'(cap_n), 32'd32);
    chk("R6 short write bits", 32'(mism(exp_frame(0, 5'h0C, 5'h03, 16'h0F3C), 0, 32, 32)), 32'd0);
    phy_resp = 16'h8001; cap_n = 0;
    wr_reg(CMD, cmd_word(1, 5'h01, 5'h01));
    wait_idle();
    chk("R6 short read length", 32'(cap_n), 32'd32);
    rd_reg(DATA, v); chk("R6 short read result", v, 32'h0000_8001);
    wr_reg(CTRL, 32'd3 << 9);
    frame_len = 64;
  endtask

  task automatic mdc_runs(input int field, input int exp_hi, input int exp_lo);
    int hi_min = 999, hi_max = 0, lo_min = 999, lo_max = 0, rises = 0, run = 0;
    bit seen_fall = 0;
    logic prv, cur;
    wr_reg(CTRL, 32'(field) << 9);
    wr_reg(DATA, 32'd0);
    wr_reg(CMD, cmd_word(0, 5'h02, 5'h02));
    prv = mdc;
    for (int i = 0; i < 64 * (field + 2) + 40; i++) begin
      @(negedge clk);
      cur = mdc;
      if (cur == prv) run++;
      else begin
        if (prv) begin
          if (run < hi_min) hi_min = run;
          if (run > hi_max) hi_max = run;
          seen_fall = 1;
        end else if (seen_fall) begin
          if (run < lo_min) lo_min = run;
          if (run > lo_max) lo_max = run;
        end
        if (cur) rises++;
        run = 1;
      end
      prv = cur;
    end
    wait_idle();
    chk("R7 mdc high min", 32'(hi_min), 32'(exp_hi));
    chk("R7 mdc high max", 32'(hi_max), 32'(exp_hi));
    chk("R7 mdc low min", 32'(lo_min), 32'(exp_lo));
    chk("R7 mdc low max", 32'(lo_max), 32'(exp_lo));
    chk("R7 mdc periods", 32'(rises), 32'd64);
    wr_reg(CTRL, 32'd3 << 9);
  endtask

  task automatic t_busy_ignore();
    logic [31:0] v;
    wr_reg(DATA, 32'h0000_1234);
    cap_n = 0; frame_len = 64;
    wr_reg(CMD, cmd_word(0, 5'h03, 5'h04));
    repeat (20) @(negedge clk);
    wr_reg(CMD, cmd_word(1, 5'h1F, 5'h1F));
    wr_reg(DATA, 32'h0000_FFFF);
    rd_reg(DATA, v); chk("R10 data write while busy", v, 32'h0000_1234);
    wait_idle();
    chk("R3 frame unchanged", 32'(mism(exp_frame(0, 5'h03, 5'h04, 16'h1234), 0, 64, 64)), 32'd0);
    repeat (50) @(negedge clk);
    chk("R3 no second frame", 32'(cap_n), 32'd64);
    rd_reg(CMD, v); chk("R3 command readback kept", v, cmd_word(0, 5'h03, 5'h04));
  endtask

  task automatic t_collide();
    logic [31:0] v;
    wr_reg(DATA, 32'h0000_0F0F);
    cap_n = 0; frame_len = 64;
    wr_reg(CMD, cmd_word(0, 5'h01, 5'h02));
    wait (cap_n == 64);
    repeat (2) @(negedge clk);
    reg_wr = 1'b1; reg_addr = CMD; reg_wdata = cmd_word(1, 5'h02, 5'h03);
    @(negedge clk);
    reg_wr = 1'b0;
    repeat (30) @(negedge clk);
    chk("R3 command on completion edge", 32'(cap_n), 32'd64);
    rd_reg(STAT, v); chk("R3 status after collision", v, 32'd0);
    rd_reg(CMD, v); chk("R1 readback after collision", v, cmd_word(0, 5'h01, 5'h02));
    wr_reg(CMD, cmd_word(0, 5'h04, 5'h05));
    rd_reg(STAT, v); chk("R2 next command accepted", v, 32'd1);
    wait_idle();
  endtask

  task automatic t_invalid();
    logic [31:0] v;
    cap_n = 0;
    wr_reg(CMD, 32'h0000_C000 | cmd_word(0, 5'h01, 5'h01));
    rd_reg(STAT, v); chk("R1 both requests ignored", v, 32'd0);
    wr_reg(CMD, 32'h0000_03FF);
    rd_reg(STAT, v); chk("R1 no request ignored", v, 32'd0);
    repeat (20) @(negedge clk);
    chk("R1 no mdc for bad command", 32'(cap_n), 32'd0);
  endtask

  task automatic t_soft_reset();
    logic [31:0] v;
    int n0;
    wr_reg(CTRL, (32'd3 << 9) | (32'd1 << 8));
    wr_reg(DATA, 32'h0000_5555);
    wr_reg(CMD, cmd_word(0, 5'h06, 5'h07));
    repeat (30) @(negedge clk);
    wr_reg(CTRL, 32'd1);
    wr_reg(CMD, cmd_word(1, 5'h06, 5'h07));
    rd_reg(CTRL, v); chk("R9 reset bit reads one", v, 32'h0000_4E01);
    rd_reg(STAT, v); chk("R9 frame aborted", v, 32'd0);
    n0 = cap_n;
    repeat (20) @(negedge clk);
    rd_reg(CTRL, v); chk("R9 reset bit clears", v, 32'h0000_4E00);
    rd_reg(DATA, v); chk("R9 data cleared", v, 32'd0);
    rd_reg(STAT, v); chk("R9 command during reset ignored", v, 32'd0);
    chk("R9 no mdc after abort", 32'(cap_n), 32'(n0));
    chk("R8 oe after abort", {31'd0, mdio_oe}, 32'd0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    t_reset();
    wr_reg(CTRL, 32'd3 << 9);
    t_write_frame();
    t_read_frame();
    t_nopre();
    mdc_runs(4, 2, 3);
    mdc_runs(0, 1, 1);
    t_busy_ignore();
    t_collide();
    t_invalid();
    t_soft_reset();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule